// File: doc/BRIEF.md
# Fractional Baud Tick Generator (transmit/receive pair)

This block turns one free-running input clock into the timing enables that a UART's transmitter and receiver need. Each direction has its own channel, and each channel has its own rate setting. That setting has four parts: an optional divide-by-4 prescaler, a 16-bit whole divisor, a 4-bit divisor fraction in sixteenths, and an oversampling choice of 16x, 8x or 4x. A channel produces a sample tick at the oversampled rate. It also produces a bit tick once per bit time, which is once every 16, 8 or 4 sample ticks.

The fraction works by stretching F out of every 16 sample periods by one prescaled cycle. An accumulator spreads these stretched periods evenly across the 16. The settings arrive on plain input pins, and a channel takes them in only when its load strobe is high. The same strobe restarts all of that channel's counters, so the new rate begins with a whole period. Both ticks are single-cycle enables in the input clock domain. The two channels never interact, so transmit and receive can run at different rates at the same time.

Top module: `frac_brg_pair`

## Requirements
- R1: While `rst` is high, all four tick outputs stay low. When reset is released, each channel runs with whole divisor 1, fraction 0, 16x oversampling and no prescaling. Its sample tick is then high on every cycle starting at the first edge after the last reset edge, and its bit tick is high on every 16th sample tick.
- R2: Take prescaling off, fraction 0 and whole divisor N ≥ 1. The sample tick then fires exactly once every N cycles, and the first tick is N edges after the load edge.
- R3: With fraction F, sample period p (counting p = 0 from load) lasts N+1 prescaled cycles when ((p·F) mod 16) + F ≥ 16, and N prescaled cycles otherwise. Any 16 consecutive periods from load therefore total 16·N+F prescaled cycles.
- R4: When the prescale select is 1, every period is measured in units of 4 input cycles. The first sample tick then comes 4·N edges after the load edge.
- R5: The oversampling field is coded 00 = 16x, 01 = 8x, 10 = 4x, and 11 is treated as 16x. The bit tick is high together with every factor-th sample tick, counted from load, and at no other time.
- R6: A whole divisor of 0 keeps both ticks of that channel low, whatever the fraction is.
- R7: Both ticks of a channel are low in the cycle after its load edge. All of that channel's timing restarts from the load edge. Changes on the setting pins while load is low have no effect.
- R8: Loading or running one channel has no effect on the other channel's ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_load | input | 1 | Transmit channel: capture the settings and restart |
| tx_div_int | input | 16 | Transmit whole divisor |
| tx_div_frac | input | 4 | Transmit divisor fraction, in sixteenths |
| tx_osr | input | 2 | Transmit oversampling code |
| tx_pre4 | input | 1 | Transmit prescale select: 1 divides by 4 |
| rx_load | input | 1 | Receive channel: capture the settings and restart |
| rx_div_int | input | 16 | Receive whole divisor |
| rx_div_frac | input | 4 | Receive divisor fraction, in sixteenths |
| rx_osr | input | 2 | Receive oversampling code |
| rx_pre4 | input | 1 | Receive prescale select: 1 divides by 4 |
| tx_sample_tick | output | 1 | Transmit oversampled tick enable |
| tx_bit_tick | output | 1 | Transmit once-per-bit tick enable |
| rx_sample_tick | output | 1 | Receive oversampled tick enable |
| rx_bit_tick | output | 1 | Receive once-per-bit tick enable |

## Verification
Every tick passes through one register. A sample tick that is due P prescaled cycles after a load therefore becomes visible on input edge P (or 4·P with prescaling), counting the load edge as edge 0. The bit tick appears on the same edge as the sample tick that completes its group. Stimulus is driven and outputs are sampled on the falling edge. The bench keeps an independent per-channel timeline, built from the period rule in R3, that starts at the falling edge just after each load or reset edge. Every cycle it compares both channels' ticks with that timeline, and in the cycle right after a load edge it expects both ticks low.

// File: rtl/brg_pkg.sv
package brg_pkg;

    localparam int BRG_INT_W   = 16;
    localparam int BRG_FRAC_W  = 4;
    localparam int BRG_PRE_DIV = 4;
    localparam int BRG_PHASE_W = 4;
    localparam int BRG_NUM_CH  = 2;

    typedef enum logic [1:0] {
        OSR_X16  = 2'b00,
        OSR_X8   = 2'b01,
        OSR_X4   = 2'b10,
        OSR_RSVD = 2'b11
    } osr_e;

    typedef struct packed {
        logic [BRG_INT_W-1:0]  whole;
        logic [BRG_FRAC_W-1:0] frac;
        osr_e                  osr;
        logic                  pre_slow;
    } brg_cfg_t;

    localparam brg_cfg_t BRG_CFG_RESET = '{
        whole:    BRG_INT_W'(1),
        frac:     '0,
        osr:      OSR_X16,
        pre_slow: 1'b0
    };

    // Terminal value of the per-bit phase counter for an oversampling code.
    function automatic logic [BRG_PHASE_W-1:0] osr_last(osr_e o);
        case (o)
            OSR_X8:  return BRG_PHASE_W'(7);
            OSR_X4:  return BRG_PHASE_W'(3);
            default: return BRG_PHASE_W'(15);
        endcase
    endfunction

endpackage

// File: rtl/brg_cfg_hold.sv
module brg_cfg_hold
    import brg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  brg_cfg_t cfg_in,
    output brg_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= BRG_CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
    parameter int PRE_DIV = 4,
    localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic slow,
    output logic pre_en
);

    localparam logic [PW-1:0] PLAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pcnt;

    assign pre_en = slow ? (pcnt == PLAST) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pcnt <= '0;
        end else if (pcnt == PLAST) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PW'(1);
        end
    end

    // R4: in divide mode an enable is never followed directly by another
    assert_prescale_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (slow && pre_en && !restart) |=> !pre_en);

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              pre_en,
    input  logic [INT_W-1:0]  whole,
    input  logic [FRAC_W-1:0] frac,
    output logic              period_end,
    output logic              sample_tick
);

    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic              stretch;
    logic              active;
    logic [INT_W:0]    limit;

    assign acc_sum = {1'b0, acc} + {1'b0, frac};
    assign stretch = acc_sum[FRAC_W];
    assign active  = (whole != '0);
    assign limit   = {1'b0, whole} + (INT_W+1)'(stretch) - (INT_W+1)'(1);

    assign period_end = pre_en && active && ({1'b0, cnt} == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt         <= '0;
            acc         <= '0;
            sample_tick <= 1'b0;
        end else begin
            sample_tick <= period_end;
            if (period_end) begin
                cnt <= '0;
                acc <= acc_sum[FRAC_W-1:0];
            end else if (pre_en && active) begin
                cnt <= cnt + INT_W'(1);
            end
        end
    end

    // R2: the period counter never runs past the whole divisor
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cnt} <= {1'b0, whole}));

    // R6: a zero divisor leaves the sample tick low
    assert_zero_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (whole == '0) |-> !sample_tick);

endmodule

// File: rtl/brg_bitcnt.sv
module brg_bitcnt
    import brg_pkg::*;
#(
    parameter int PHASE_W = BRG_PHASE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic period_end,
    input  osr_e osr,
    input  logic sample_tick,
    output logic bit_tick
);

    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] last;
    logic               bit_end;

    assign last    = PHASE_W'(osr_last(osr));
    assign bit_end = period_end && (phase == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase    <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= bit_end;
            if (period_end) begin
                phase <= bit_end ? '0 : phase + PHASE_W'(1);
            end
        end
    end

    // R5: a bit tick only ever coincides with a sample tick
    assert_bit_on_sample_R5: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

endmodule

// File: rtl/brg_channel.sv
module brg_channel
    import brg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  brg_cfg_t cfg_in,
    output logic     sample_tick,
    output logic     bit_tick
);

    brg_cfg_t cfg;
    logic     pre_en;
    logic     period_end;

    brg_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg)
    );

    brg_prescale #(.PRE_DIV(BRG_PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .slow    (cfg.pre_slow),
        .pre_en  (pre_en)
    );

    brg_divider #(.INT_W(BRG_INT_W), .FRAC_W(BRG_FRAC_W)) u_div (
        .clk         (clk),
        .rst         (rst),
        .restart     (load),
        .pre_en      (pre_en),
        .whole       (cfg.whole),
        .frac        (cfg.frac),
        .period_end  (period_end),
        .sample_tick (sample_tick)
    );

    brg_bitcnt #(.PHASE_W(BRG_PHASE_W)) u_bit (
        .clk         (clk),
        .rst         (rst),
        .restart     (load),
        .period_end  (period_end),
        .osr         (cfg.osr),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    // R7: both ticks are quiet in the cycle after a load edge
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (!sample_tick && !bit_tick));

endmodule

// File: rtl/frac_brg_pair.sv
module frac_brg_pair
    import brg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_load,
    input  logic [BRG_INT_W-1:0]  tx_div_int,
    input  logic [BRG_FRAC_W-1:0] tx_div_frac,
    input  logic [1:0]            tx_osr,
    input  logic                  tx_pre4,
    input  logic                  rx_load,
    input  logic [BRG_INT_W-1:0]  rx_div_int,
    input  logic [BRG_FRAC_W-1:0] rx_div_frac,
    input  logic [1:0]            rx_osr,
    input  logic                  rx_pre4,
    output logic                  tx_sample_tick,
    output logic                  tx_bit_tick,
    output logic                  rx_sample_tick,
    output logic                  rx_bit_tick
);

    logic     ch_load   [BRG_NUM_CH];
    brg_cfg_t ch_cfg    [BRG_NUM_CH];
    logic     ch_sample [BRG_NUM_CH];
    logic     ch_bit    [BRG_NUM_CH];

    assign ch_load[0] = tx_load;
    assign ch_load[1] = rx_load;
    assign ch_cfg[0]  = '{whole: tx_div_int, frac: tx_div_frac,
                          osr: osr_e'(tx_osr), pre_slow: tx_pre4};
    assign ch_cfg[1]  = '{whole: rx_div_int, frac: rx_div_frac,
                          osr: osr_e'(rx_osr), pre_slow: rx_pre4};

    for (genvar g = 0; g < BRG_NUM_CH; g++) begin : g_ch
        brg_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .load        (ch_load[g]),
            .cfg_in      (ch_cfg[g]),
            .sample_tick (ch_sample[g]),
            .bit_tick    (ch_bit[g])
        );
    end

    assign tx_sample_tick = ch_sample[0];
    assign tx_bit_tick    = ch_bit[0];
    assign rx_sample_tick = ch_sample[1];
    assign rx_bit_tick    = ch_bit[1];

endmodule

// File: tb/test_frac_brg_pair.sv
`timescale 1ns/1ps
module test_frac_brg_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_load = 1'b0, rx_load = 1'b0;
    logic [15:0] tx_div_int = 16'd1, rx_div_int = 16'd1;
    logic [3:0]  tx_div_frac = 4'd0, rx_div_frac = 4'd0;
    logic [1:0]  tx_osr = 2'b00, rx_osr = 2'b00;
    logic        tx_pre4 = 1'b0, rx_pre4 = 1'b0;
    logic        tx_sample_tick, tx_bit_tick, rx_sample_tick, rx_bit_tick;

    always #2.5 clk = ~clk;

    frac_brg_pair i_frac_brg_pair (
        .clk(clk), .rst(rst),
        .tx_load(tx_load), .tx_div_int(tx_div_int), .tx_div_frac(tx_div_frac),
        .tx_osr(tx_osr), .tx_pre4(tx_pre4),
        .rx_load(rx_load), .rx_div_int(rx_div_int), .rx_div_frac(rx_div_frac),
        .rx_osr(rx_osr), .rx_pre4(rx_pre4),
        .tx_sample_tick(tx_sample_tick), .tx_bit_tick(tx_bit_tick),
        .rx_sample_tick(rx_sample_tick), .rx_bit_tick(rx_bit_tick)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    // per-channel expected timeline
    int m_n[2], m_f[2], m_fac[2], m_pre[2];
    int m_k[2], m_next[2], m_acc[2], m_cnt[2];
    bit m_pend[2];

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            $display("FAIL watchdog all: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int fac_of(int code);
        case (code)
            1: return 8;
            2: return 4;
            default: return 16;
        endcase
    endfunction

    task automatic chk(string what, int c, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s ch%0d %s actual=%0b expected=%0b at t=%0t",
                     cur_req, c, what, act, exp, $time);
        end
    endtask

    task automatic model_restart(int c);
        m_k[c]    = 0;
        m_acc[c]  = 0;
        m_cnt[c]  = 0;
        m_next[c] = m_pre[c] * (m_n[c] + ((m_f[c] >= 16) ? 1 : 0));
    endtask

    task automatic tick_cycle();
        @(negedge clk);
        for (int c = 0; c < 2; c++) begin
            logic as, ab, es, eb;
            as = (c == 0) ? tx_sample_tick : rx_sample_tick;
            ab = (c == 0) ? tx_bit_tick : rx_bit_tick;
            es = 1'b0;
            eb = 1'b0;
            if (m_pend[c]) begin
                m_pend[c] = 1'b0;
                model_restart(c);   // R7: cycle after load edge is quiet
            end else begin
                m_k[c]++;
                if (m_n[c] != 0 && m_k[c] == m_next[c]) begin
                    int carry;
                    es = 1'b1;
                    m_cnt[c]++;
                    eb = ((m_cnt[c] % m_fac[c]) == 0);
                    m_acc[c] = (m_acc[c] + m_f[c]) % 16;
                    carry = ((m_acc[c] + m_f[c]) >= 16) ? 1 : 0;
                    m_next[c] += m_pre[c] * (m_n[c] + carry);
                end
            end
            chk("sample_tick", c, as, es);
            chk("bit_tick", c, ab, eb);
        end
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) tick_cycle();
    endtask

    task automatic load_ch(int c, int n, int f, int osr, bit pre);
        if (c == 0) begin
            tx_div_int = 16'(n); tx_div_frac = 4'(f); tx_osr = 2'(osr);
            tx_pre4 = pre; tx_load = 1'b1;
        end else begin
            rx_div_int = 16'(n); rx_div_frac = 4'(f); rx_osr = 2'(osr);
            rx_pre4 = pre; rx_load = 1'b1;
        end
        m_n[c] = n; m_f[c] = f; m_fac[c] = fac_of(osr); m_pre[c] = pre ? 4 : 1;
        m_pend[c] = 1'b1;
        tick_cycle();
        tx_load = 1'b0;
        rx_load = 1'b0;
    endtask

    task automatic t_reset();
        cur_req = "R1";
        for (int c = 0; c < 2; c++) begin
            m_n[c] = 1; m_f[c] = 0; m_fac[c] = 16; m_pre[c] = 1; m_pend[c] = 1'b0;
        end
        repeat (3) begin
            @(negedge clk);
            chk("sample_tick in reset", 0, tx_sample_tick, 1'b0);
            chk("bit_tick in reset", 0, tx_bit_tick, 1'b0);
            chk("sample_tick in reset", 1, rx_sample_tick, 1'b0);
            chk("bit_tick in reset", 1, rx_bit_tick, 1'b0);
        end
        rst = 1'b0;
        model_restart(0);
        model_restart(1);
        run(80);
    endtask

    task automatic t_integer();
        cur_req = "R2";
        load_ch(0, 5, 0, 0, 1'b0);
        run(200);
    endtask

    task automatic t_fraction();
        cur_req = "R3";
        load_ch(0, 3, 5, 1, 1'b0);
        run(260);
        load_ch(0, 2, 15, 0, 1'b0);
        run(200);
        load_ch(1, 1, 8, 2, 1'b0);
        run(120);
    endtask

    task automatic t_prescale();
        cur_req = "R4";
        load_ch(0, 3, 0, 2, 1'b1);
        run(200);
        load_ch(1, 2, 4, 1, 1'b1);
        run(300);
    endtask

    task automatic t_osr();
        cur_req = "R5";
        load_ch(0, 1, 0, 2, 1'b0);
        run(40);
        load_ch(0, 1, 0, 1, 1'b0);
        run(40);
        load_ch(0, 1, 0, 3, 1'b0);
        run(70);
    endtask

    task automatic t_zero();
        cur_req = "R6";
        load_ch(0, 0, 0, 2, 1'b0);
        load_ch(1, 0, 7, 0, 1'b1);
        run(300);
    endtask

    task automatic t_restart();
        cur_req = "R7";
        load_ch(0, 10, 0, 2, 1'b0);
        run(7);
        load_ch(0, 10, 0, 2, 1'b0);   // mid-period reload: no partial period
        tx_div_int = 16'd2;           // pin change without load: ignored
        tx_osr = 2'b01;
        tx_pre4 = 1'b1;
        run(150);
    endtask

    task automatic t_indep();
        cur_req = "R8";
        load_ch(0, 3, 0, 1, 1'b0);
        run(13);
        load_ch(1, 7, 3, 2, 1'b1);
        run(100);
        load_ch(0, 4, 9, 0, 1'b0);    // reload tx while rx is mid-run
        run(300);
    endtask

    initial begin
        t_reset();
        t_integer();
        t_fraction();
        t_prescale();
        t_osr();
        t_zero();
        t_restart();
        t_indep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule